// File: doc/BRIEF.md
# Master-Clock to Frame-Clock Ratio Monitor

This block checks that a master clock and a frame (left/right) clock keep the relation that a chosen operating point needs. It runs on a free-running reference clock. Both audio clocks enter as plain sampled inputs and are synchronized into the reference domain. It counts master-clock rising edges over each whole frame-clock period and compares the count with an expected ratio. The expected ratio comes from a rate-mode bit and a 2-bit ratio code.

There are two separate fault flags. `ratio_err` shows a ratio mismatch. Single-period noise cannot change it. `mclk_missing` shows that master-clock edges have stopped arriving, for example while the frame clock keeps toggling. Both flags are set by reset. Both stay set until the first complete matching measurement after reset.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: With `rate_high`=0, ratio code c (0..3) expects 128×(c+1) master-clock edges per frame period, i.e. 128, 256, 384, 512.
- R2: With `rate_high`=1, ratio code c expects 64×(c+1) edges per frame period, i.e. 64, 128, 192, 256. The same code therefore means half the base-mode value.
- R3: A measurement counts the master-clock rising edges from one frame-clock rising edge to the next. The first frame-clock edge after reset only starts a measurement.
- R4: A measured count within ±2 of the expected ratio is a match. A count 3 or more away is a mismatch.
- R5: `ratio_err` rises only after 2 consecutive mismatching measurements. A single mismatch between matches leaves it low.
- R6: Once set, `ratio_err` falls only after 2 consecutive matching measurements.
- R7: `mclk_missing` rises after 1024 consecutive reference cycles with no master-clock edge detected. It stays low while edges keep arriving within that window.
- R8: Outside the post-reset hold, `mclk_missing` falls in the cycle after the next detected master-clock edge.
- R9: A synchronous active-low reset clears the counters and sets both flags. Both flags then stay high, even if master-clock edges arrive, until the first complete matching measurement. That single measurement clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mclk_in | input | 1 | Master clock, sampled asynchronously |
| fclk_in | input | 1 | Frame (left/right) clock, sampled asynchronously |
| rate_high | input | 1 | 0 selects base-rate ratios, 1 selects high-rate ratios |
| ratio_sel | input | 2 | Ratio code 0..3 |
| ratio_err | output | 1 | Filtered ratio mismatch flag |
| mclk_missing | output | 1 | Master-clock absence flag |

## Verification
Suppose the edge counter holds a wrong value or fails to restart. The monitor then sees mismatches at the correct ratio, and `ratio_err` shows this within two frame periods of settling. If the run-length counters stick, a single bad period sets the flag, or two good periods fail to clear it, and this shows within one or two frames of the disturbance. An idle counter that is off by a margin moves the rise of `mclk_missing` out of the window between 900 and 1100 cycles after the clock stops. If the post-reset hold is broken, the flags are released either before the first full frame period or later than it.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
    localparam int unsigned BASE_STEP = 128;
    localparam int unsigned HIGH_STEP = 64;
    localparam int unsigned CODE_W    = 2;
endpackage

// File: rtl/mrm_edge_sync.sv
module mrm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], din};
        st_d.last = st_q.pipe[STAGES-1];
        rise      = st_q.pipe[STAGES-1] & ~st_q.last;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/mrm_ratio_lut.sv
module mrm_ratio_lut
    import mrm_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic              rate_high,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  expected
);
    localparam int unsigned MULT_W = CNT_W + CODE_W + 1;

    logic [MULT_W-1:0] step;
    logic [MULT_W-1:0] prod;

    always_comb begin
        step     = rate_high ? MULT_W'(HIGH_STEP) : MULT_W'(BASE_STEP);
        prod     = (MULT_W'(code) + MULT_W'(1)) * step;
        expected = CNT_W'(prod);
    end
endmodule

// File: rtl/mrm_period_meter.sv
module mrm_period_meter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_rise,
    input  logic             fclk_rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } meter_st_t;

    meter_st_t st_d, st_q;
    logic [CNT_W-1:0] sum;

    always_comb begin
        st_d       = st_q;
        sum        = (&st_q.cnt) ? st_q.cnt : st_q.cnt + CNT_W'(mclk_rise);
        meas_valid = 1'b0;
        meas_count = sum;
        if (fclk_rise) begin
            meas_valid = st_q.armed;
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else begin
            st_d.cnt   = sum;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: between frame edges the count never decreases
    a_r3_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !fclk_rise |=> st_q.cnt >= $past(st_q.cnt));
    // R3: no measurement is reported without a frame edge
    a_r3_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> fclk_rise);
endmodule

// File: rtl/mrm_fault_filter.sv
module mrm_fault_filter #(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned TOL        = 2,
    parameter int unsigned RUN_LEN    = 2,
    parameter int unsigned MISS_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_rise,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_count,
    input  logic [CNT_W-1:0] expected,
    output logic             ratio_err,
    output logic             mclk_missing
);
    localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1);
    localparam int unsigned IDLE_W = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        logic              err;
        logic              missing;
        logic              init;
        logic [RUN_W-1:0]  bad_run;
        logic [RUN_W-1:0]  good_run;
        logic [IDLE_W-1:0] idle;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CNT_W-1:0] diff;
    logic             meas_ok;

    always_comb begin
        st_d    = st_q;
        diff    = (meas_count >= expected) ? meas_count - expected
                                           : expected - meas_count;
        meas_ok = diff <= CNT_W'(TOL);

        if (mclk_rise) begin
            st_d.idle = '0;
            if (!st_q.init) begin
                st_d.missing = 1'b0;
            end
        end else if (st_q.idle >= IDLE_W'(MISS_LIMIT - 1)) begin
            st_d.missing = 1'b1;
        end else begin
            st_d.idle = st_q.idle + 1'b1;
        end

        if (meas_valid) begin
            if (meas_ok) begin
                st_d.bad_run  = '0;
                st_d.good_run = (st_q.good_run == RUN_W'(RUN_LEN)) ? st_q.good_run
                                                                   : st_q.good_run + 1'b1;
                if (st_q.init) begin
                    st_d.init    = 1'b0;
                    st_d.err     = 1'b0;
                    st_d.missing = 1'b0;
                end else if (st_d.good_run == RUN_W'(RUN_LEN)) begin
                    st_d.err = 1'b0;
                end
            end else begin
                st_d.good_run = '0;
                st_d.bad_run  = (st_q.bad_run == RUN_W'(RUN_LEN)) ? st_q.bad_run
                                                                  : st_q.bad_run + 1'b1;
                if (st_d.bad_run == RUN_W'(RUN_LEN)) begin
                    st_d.err = 1'b1;
                end
            end
        end

        if (!rst_n) begin
            st_d         = '0;
            st_d.err     = 1'b1;
            st_d.missing = 1'b1;
            st_d.init    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ratio_err    = st_q.err;
    assign mclk_missing = st_q.missing;

    // R5: the error flag only rises on a failing measurement
    a_r5_rise_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_err) |-> $past(meas_valid && !meas_ok));
    // R6: the error flag only falls on a passing measurement
    a_r6_fall_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_err) |-> $past(meas_valid && meas_ok));
    // R8: an edge outside the reset hold clears the missing flag
    a_r8_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_rise && !st_q.init) |=> !mclk_missing);
    // R7: the missing flag never rises in the cycle after an edge
    a_r7_no_rise_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_missing) |-> !$past(mclk_rise));
endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor
    import mrm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned TOL         = 2,
    parameter int unsigned RUN_LEN     = 2,
    parameter int unsigned MISS_LIMIT  = 1024
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       mclk_in,
    input  logic       fclk_in,
    input  logic       rate_high,
    input  logic [1:0] ratio_sel,
    output logic       ratio_err,
    output logic       mclk_missing
);
    logic             mclk_rise;
    logic             fclk_rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;
    logic [CNT_W-1:0] expected;

    mrm_edge_sync #(.STAGES(SYNC_STAGES)) i_mclk_sync (
        .clk(clk_ref), .rst_n(rst_n), .din(mclk_in), .rise(mclk_rise));

    mrm_edge_sync #(.STAGES(SYNC_STAGES)) i_fclk_sync (
        .clk(clk_ref), .rst_n(rst_n), .din(fclk_in), .rise(fclk_rise));

    mrm_period_meter #(.CNT_W(CNT_W)) i_meter (
        .clk(clk_ref), .rst_n(rst_n), .mclk_rise(mclk_rise), .fclk_rise(fclk_rise),
        .meas_valid(meas_valid), .meas_count(meas_count));

    mrm_ratio_lut #(.CNT_W(CNT_W)) i_lut (
        .rate_high(rate_high), .code(ratio_sel), .expected(expected));

    mrm_fault_filter #(
        .CNT_W(CNT_W), .TOL(TOL), .RUN_LEN(RUN_LEN), .MISS_LIMIT(MISS_LIMIT)
    ) i_filter (
        .clk(clk_ref), .rst_n(rst_n), .mclk_rise(mclk_rise),
        .meas_valid(meas_valid), .meas_count(meas_count), .expected(expected),
        .ratio_err(ratio_err), .mclk_missing(mclk_missing));
endmodule

// File: tb/test_mclk_ratio_monitor.sv
module test_mclk_ratio_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0;
    logic       fclk = 1'b0;
    logic       rate_high = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       ratio_err;
    logic       mclk_missing;
    logic       mclk_en = 1'b1;
    int         frame_len = 128;
    int         t = 0;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    mclk_ratio_monitor i_mclk_ratio_monitor (
        .clk_ref(clk), .rst_n(rst_n), .mclk_in(mclk), .fclk_in(fclk),
        .rate_high(rate_high), .ratio_sel(ratio_sel),
        .ratio_err(ratio_err), .mclk_missing(mclk_missing));

    // master clock: 4 reference cycles per period; frame: frame_len master periods
    always @(negedge clk) begin
        t = t + 1;
        mclk <= mclk_en && ((t % 4) < 2);
        fclk <= ((t / (frame_len * 2)) % 2) == 0;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic hi, input logic [1:0] sel, input int frame);
        @(posedge clk);
        rate_high = hi;
        ratio_sel = sel;
        frame_len = frame;
        t = 0;
    endtask

    task automatic wait_frames(input int n);
        repeat (n * 4 * frame_len) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        mclk_en = 1'b1;
        setup(1'b0, 2'd0, 128);
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        chk("R9 err in reset", ratio_err, 1);
        chk("R9 missing in reset", mclk_missing, 1);
        @(posedge clk);
        rst_n = 1'b1;
        t = 4 * 128 - 100;
        repeat (50) @(posedge clk);
        #1;
        chk("R9 err held before measurement", ratio_err, 1);
        chk("R9 missing held despite edges", mclk_missing, 1);
        repeat (650) @(posedge clk);
        #1;
        chk("R9 err cleared by first good", ratio_err, 0);
        chk("R9 missing cleared by first good", mclk_missing, 0);
    endtask

    task automatic t_table(input logic hi);
        for (int sel = 0; sel < 4; sel++) begin
            int exp_ratio;
            exp_ratio = (hi ? 64 : 128) * (sel + 1);
            setup(hi, 2'(sel), exp_ratio);
            wait_frames(6);
            chk(hi ? "R2 R3 high-rate ratio accepted" : "R1 R3 base-rate ratio accepted",
                ratio_err, 0);
            chk("R7 no missing with clock", mclk_missing, 0);
        end
    endtask

    task automatic t_cross_mode();
        setup(1'b0, 2'd1, 128);
        wait_frames(4);
        chk("R1 R5 base code1 rejects 128", ratio_err, 1);
        @(posedge clk);
        rate_high = 1'b1;
        wait_frames(4);
        chk("R2 R6 high code1 accepts 128", ratio_err, 0);
    endtask

    task automatic t_tolerance();
        setup(1'b0, 2'd0, 130);
        wait_frames(6);
        chk("R4 +2 accepted", ratio_err, 0);
        setup(1'b0, 2'd0, 126);
        wait_frames(6);
        chk("R4 -2 accepted", ratio_err, 0);
        setup(1'b0, 2'd0, 131);
        wait_frames(6);
        chk("R4 +3 rejected", ratio_err, 1);
        setup(1'b0, 2'd0, 125);
        wait_frames(6);
        chk("R4 -3 rejected", ratio_err, 1);
    endtask

    task automatic t_filter();
        setup(1'b0, 2'd0, 128);
        wait_frames(6);
        chk("R6 settled good", ratio_err, 0);
        @(posedge fclk);
        repeat (256) @(posedge clk);
        ratio_sel = 2'd1;
        repeat (512) @(posedge clk);
        ratio_sel = 2'd0;
        #1;
        chk("R5 single bad ignored", ratio_err, 0);
        repeat (512) @(posedge clk);
        #1;
        chk("R5 stays low after good", ratio_err, 0);
        ratio_sel = 2'd1;
        repeat (1024) @(posedge clk);
        ratio_sel = 2'd0;
        #1;
        chk("R5 two bad set error", ratio_err, 1);
        repeat (512) @(posedge clk);
        #1;
        chk("R6 one good not enough", ratio_err, 1);
        repeat (512) @(posedge clk);
        #1;
        chk("R6 two good clear error", ratio_err, 0);
    endtask

    task automatic t_missing();
        @(posedge clk);
        mclk_en = 1'b0;
        repeat (900) @(posedge clk);
        #1;
        chk("R7 not yet missing", mclk_missing, 0);
        repeat (200) @(posedge clk);
        #1;
        chk("R7 missing after 1024 idle", mclk_missing, 1);
        mclk_en = 1'b1;
        repeat (12) @(posedge clk);
        #1;
        chk("R8 cleared on next edge", mclk_missing, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_table(1'b0);
        t_table(1'b1);
        t_cross_mode();
        t_tolerance();
        t_filter();
        t_missing();
        finish_run();
    end
endmodule